// File: doc/BRIEF.md
# Two-Level Carry-Select Adder

This block adds two unsigned operands and a carry-in with no clock and no state. It returns a sum as wide as the operands and a carry-out. The carry does not travel through every bit. The operands are split in two halves. The lower half is added with the real carry-in. The upper half is added twice in parallel: one copy assumes an incoming carry of 0 and the other assumes 1. A 2:1 selector then chooses between them, and the lower half's carry-out drives that choice.

The same split is used again inside each half. Each half-width adder is itself a carry-select adder, built from quarter-width ripple-carry chains of full adders. With the default 32-bit width, the longest carry path is therefore one 8-bit ripple chain plus two selector stages, instead of 32 chained full adders. The final carry-out comes from whichever upper speculative adder is selected.

Top module: `csel_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of opa + opb + cin for every operand pair and carry-in.
- R2: `cout` equals bit WIDTH of opa + opb + cin, so {cout, sum} equals the full WIDTH+1-bit total.
- R3: When the lower half produces no carry, the upper half of `sum` equals opa_hi + opb_hi. When it produces a carry, the upper half equals opa_hi + opb_hi + 1. The two speculative upper results always differ by exactly one.
- R4: All-ones operands with cin = 1 give an all-ones `sum` and `cout` = 1.
- R5: Zero operands give `sum` equal to cin (value 0 or 1) and `cout` = 0.
- R6: The outputs follow a change at the inputs with no clock edge. Each new input set yields its own result.
- R7: A carry produced in the lowest ripple piece reaches every piece boundary (bits WIDTH/4, WIDTH/2, 3·WIDTH/4) and the carry-out. For example, all-ones plus 0 with cin = 1 gives `sum` = 0 and `cout` = 1.
- R8: Each ripple piece, whether it runs with the real carry or a forced one, gives {carry-out, sum} equal to the arithmetic total of its own inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa  | input  | WIDTH | First addend |
| opb  | input  | WIDTH | Second addend |
| cin  | input  | 1     | Carry into bit 0 |
| sum  | output | WIDTH | Low WIDTH bits of the total |
| cout | output | 1     | Carry out of the top bit |

## Verification
The bench builds the block twice. The first build uses WIDTH = 8, which gives 2-bit ripple pieces. At that size every operand pair and both carry-in values can be swept, so every selector decision at both levels is exercised, along with every carry crossing at every piece boundary. The second build uses the default WIDTH = 32. It is driven with boundary operands that force a carry across the 8-, 16- and 24-bit seams, with alternating patterns and all-ones values, and with a run of random pairs.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // sum bit of one full-adder cell
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // carry of one full-adder cell: majority of the three inputs
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;

  assign chain[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_cell
    assign s[i]       = csel_pkg::fa_sum  (a[i], b[i], chain[i]);
    assign chain[i+1] = csel_pkg::fa_carry(a[i], b[i], chain[i]);
  end

  assign co = chain[W];

  // R8: the gate chain matches the arithmetic total of this piece
  always_comb begin
    if (!$isunknown({a, b, ci, s, co})) begin
      assert_leaf_total_R8: assert ({co, s} == ({1'b0, a} + {1'b0, b} + (W+1)'(ci)))
        else $error("leaf total mismatch");
    end
  end
endmodule

// File: rtl/csel_pick.sv
module csel_pick #(
  parameter int W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] s0,
  input  logic         c0,
  input  logic [W-1:0] s1,
  input  logic         c1,
  output logic [W-1:0] s,
  output logic         c
);
  assign {c, s} = sel ? {c1, s1} : {c0, s0};

  // R3: the carry-1 guess is always one above the carry-0 guess
  always_comb begin
    if (!$isunknown({s0, c0, s1, c1})) begin
      assert_spec_gap_R3: assert ({c1, s1} == ({c0, s0} + (W+1)'(1)))
        else $error("speculative pair inconsistent");
    end
  end
endmodule

// File: rtl/csel_half.sv
module csel_half #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  localparam int P = W / 2;

  logic [P-1:0] lo_sum, hi_sum0, hi_sum1;
  logic         lo_carry, hi_carry0, hi_carry1;

  csel_ripple #(.W(P)) u_lo  (.a(a[P-1:0]), .b(b[P-1:0]), .ci(ci),   .s(lo_sum),  .co(lo_carry));
  csel_ripple #(.W(P)) u_hi0 (.a(a[W-1:P]), .b(b[W-1:P]), .ci(1'b0), .s(hi_sum0), .co(hi_carry0));
  csel_ripple #(.W(P)) u_hi1 (.a(a[W-1:P]), .b(b[W-1:P]), .ci(1'b1), .s(hi_sum1), .co(hi_carry1));

  csel_pick #(.W(P)) u_pick (
    .sel(lo_carry),
    .s0(hi_sum0), .c0(hi_carry0),
    .s1(hi_sum1), .c1(hi_carry1),
    .s(s[W-1:P]), .c(co)
  );

  assign s[P-1:0] = lo_sum;
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int HALF = WIDTH / 2;

  logic [HALF-1:0] lo_sum, hi_sum0, hi_sum1;
  logic            lo_carry, hi_carry0, hi_carry1;

  csel_half #(.W(HALF)) u_lo  (.a(opa[HALF-1:0]),     .b(opb[HALF-1:0]),     .ci(cin),  .s(lo_sum),  .co(lo_carry));
  csel_half #(.W(HALF)) u_hi0 (.a(opa[WIDTH-1:HALF]), .b(opb[WIDTH-1:HALF]), .ci(1'b0), .s(hi_sum0), .co(hi_carry0));
  csel_half #(.W(HALF)) u_hi1 (.a(opa[WIDTH-1:HALF]), .b(opb[WIDTH-1:HALF]), .ci(1'b1), .s(hi_sum1), .co(hi_carry1));

  csel_pick #(.W(HALF)) u_pick (
    .sel(lo_carry),
    .s0(hi_sum0), .c0(hi_carry0),
    .s1(hi_sum1), .c1(hi_carry1),
    .s(sum[WIDTH-1:HALF]), .c(cout)
  );

  assign sum[HALF-1:0] = lo_sum;

  always_comb begin
    if (!$isunknown({opa, opb, cin, sum, cout})) begin
      // R1 / R2: full total across both levels
      assert_total_R2: assert ({cout, sum} == ({1'b0, opa} + {1'b0, opb} + (WIDTH+1)'(cin)))
        else $error("total mismatch");
      // R3: the upper half follows the lower half's carry
      assert_upper_R3: assert (sum[WIDTH-1:HALF] ==
                               HALF'(opa[WIDTH-1:HALF] + opb[WIDTH-1:HALF] + HALF'(lo_carry)))
        else $error("upper half wrong");
      // R4: all-ones with carry-in
      if (&opa && &opb && cin) begin
        assert_allones_R4: assert (&sum && cout) else $error("all-ones case wrong");
      end
    end
  end
endmodule

// File: tb/csel_adder_bench.sv
module csel_adder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic done = 1'b0;

  logic [31:0] a32, b32, s32;
  logic        c32, co32;
  logic [7:0]  a8, b8, s8;
  logic        c8, co8;

  csel_adder #(.WIDTH(32)) u_csel_adder (.opa(a32), .opb(b32), .cin(c32), .sum(s32), .cout(co32));
  csel_adder #(.WIDTH(8))  u_csel_adder_w8 (.opa(a8), .opb(b8), .cin(c8), .sum(s8), .cout(co8));

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic try32(input string tag, input logic [31:0] x, input logic [31:0] y, input logic c);
    logic [32:0] tot;
    a32 = x; b32 = y; c32 = c;
    #1;
    tot = {1'b0, x} + {1'b0, y} + 33'(c);
    check(tag, {co32, s32}, tot);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    a32 = '0; b32 = '0; c32 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R5: zero operands
    try32("R5 zero cin0", 32'h0, 32'h0, 1'b0);
    try32("R5 zero cin1", 32'h0, 32'h0, 1'b1);
    // R4: all ones plus carry
    try32("R4 allones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    // R7: carry from bit 0 to the top
    try32("R7 wrap", 32'hFFFF_FFFF, 32'h0, 1'b1);
    try32("R7 seam8", 32'h0000_00FF, 32'h1, 1'b0);
    try32("R7 seam24", 32'h00FF_FFFF, 32'h1, 1'b0);
    try32("R7 alternating", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    // R3: lower-half carry present / absent
    try32("R3 lo carry", 32'h1234_FFFF, 32'h0000_0001, 1'b0);
    try32("R3 no lo carry", 32'h1234_FFFE, 32'h0000_0001, 1'b0);
    try32("R3 hi carry out", 32'h8000_8000, 32'h8000_8000, 1'b0);
    // R6: back-to-back input changes with no clock edge between them
    try32("R6 step a", 32'h0000_0010, 32'h0000_0020, 1'b0);
    try32("R6 step b", 32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    // R1 / R2: random operands
    for (int i = 0; i < 2000; i++) begin
      try32("R1 R2 random", $urandom, $urandom, 1'($urandom));
    end

    // R1, R2, R8: exhaustive sweep on the small build
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int c = 0; c < 2; c++) begin
          a8 = x[7:0]; b8 = y[7:0]; c8 = c[0];
          #1;
          check("R1 sum w8", 33'(s8), 33'((x + y + c) % 256));
          check("R2 cout w8", 33'(co8), 33'((x + y + c) / 256));
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule